// File: doc/BRIEF.md
# DMA Channel with Buffered Reload

This block is one channel of a direct memory access engine. It copies a block of data units from a source address range to a destination address range. Each external transfer request moves exactly one unit. For each unit the channel asks for the bus, waits for a grant, presents both addresses until the bus reports the unit done, and then hands the bus back. Processor and channel cycles therefore interleave unit by unit.

Software programs the channel through a small register port with eight selectable words. The source, destination and count words are double-buffered. A write always lands in a pending copy, and the working copy that drives the bus is loaded from the pending copy only when a block starts. The next block can therefore be set up while the current one runs. The addressing-mode word is frozen while the channel is enabled. A control word starts a block, or aborts one through an init bit. Completion sets a terminal-count flag, which is cleared by reading it, and raises a one-cycle interrupt pulse.

The controller is a four-state machine:
- IDLE is the disabled state. IDLE goes to ARMED on a start command.
- ARMED is enabled and waiting for a request. ARMED goes to REQ on a request, or back to IDLE on an abort.
- REQ drives the bus request. REQ goes to MOVE on a grant, or back to IDLE on an abort.
- MOVE owns the bus. When the unit is done, MOVE goes to ARMED if units remain. It goes to IDLE when the last unit has finished or when an abort is pending.

Top module: `dmar_chan`

## Requirements
- R1: After reset the channel is disabled and the terminal-count flag is 0. The bus request and the interrupt are low. The pending words and the mode word are 0.
- R2: A control write (select 4) with bit 0 (enable) set and bit 1 (init) clear, while the channel is disabled, does three things. It copies the pending source, destination and count into the working registers. It sets enable. It clears the terminal-count flag.
- R3: A request is taken only while the channel is enabled and waiting. A request taken at a clock edge raises the bus request for the following cycle. The request stays high until the edge where the unit is done. Requests made while the channel is disabled leave the bus request low.
- R4: Mode word bits [1:0] set the source mode and bits [3:2] set the destination mode. The encodings are 00 increment, 01 decrement, and 10 or 11 fixed. After every completed unit each working address moves by STEP, modulo 2^ADDR_W. The bus addresses of a unit are the working addresses held before that unit completes.
- R5: A count value N gives N+1 units. The working count drops by one after each non-final unit. The unit moved while the count reads 0 is the last one.
- R6: In the cycle after the last unit completes, three things hold: the terminal-count flag reads 1, enable reads 0, and the interrupt is high for exactly that one cycle.
- R7: The control word reads back enable in bit 0 and the terminal-count flag in bit 2. A read of it (select 4 with the read strobe) clears the flag.
- R8: Writes to the source, destination or count words (selects 0, 1, 2) while the channel is enabled change only the pending copies. The working values (selects 5, 6, 7) are unchanged, and the next start loads the new values.
- R9: A mode word write (select 3) while the channel is enabled is ignored. Its read-back and the stepping direction stay as they were.
- R10: A control write with bit 1 set aborts an enabled channel. While waiting or requesting, the channel stops at once. While moving, the bus stays held until the unit is done and the channel then stops. An abort never sets the terminal-count flag and never raises the interrupt.
- R11: A start write while the channel is already enabled has no effect on the working registers. When bit 1 and bit 0 are both set, init takes priority and no block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears the flag when select is 4) |
| cfg_sel | input | 3 | Register select: 0 src, 1 dst, 2 count, 3 mode, 4 control, 5 working src, 6 working dst, 7 working count |
| cfg_wdata | input | REG_W | Write data |
| cfg_rdata | output | REG_W | Read data for the selected word, zero-extended |
| xfer_req | input | 1 | Request to move one unit |
| bus_req | output | 1 | Bus request, held until the unit is done |
| bus_gnt | input | 1 | Bus grant |
| bus_done | input | 1 | Unit-done strobe from the bus |
| bus_src_addr | output | ADDR_W | Working source address |
| bus_dst_addr | output | ADDR_W | Working destination address |
| irq_tc | output | 1 | One-cycle transfer-end interrupt |

## Verification
The bench builds the channel with ADDR_W = 16, CNT_W = 8 and STEP = 2. The 16-bit address width brings wraparound within reach in a few units: one vector decrements a source address below zero and another increments one past 0xFFFF. The step of 2 separates a stepped address from an off-by-one error. The narrow count keeps the readback of the working count word small while still covering single-unit blocks and multi-unit blocks.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_REQ   = 2'd2,
        ST_MOVE  = 2'd3
    } dmar_state_e;

    localparam logic [1:0] AM_INC = 2'b00;
    localparam logic [1:0] AM_DEC = 2'b01;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_MODE = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;
    localparam logic [2:0] SEL_WSRC = 3'd5;
    localparam logic [2:0] SEL_WDST = 3'd6;
    localparam logic [2:0] SEL_WCNT = 3'd7;

    localparam int CTL_EN   = 0;
    localparam int CTL_INIT = 1;
    localparam int CTL_TC   = 2;

endpackage

// File: rtl/dmar_cfg.sv
module dmar_cfg
    import dmar_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [2:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              active,
    input  logic              fin_ev,
    input  logic [ADDR_W-1:0] work_src,
    input  logic [ADDR_W-1:0] work_dst,
    input  logic [CNT_W-1:0]  work_cnt,
    output logic [ADDR_W-1:0] pend_src,
    output logic [ADDR_W-1:0] pend_dst,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic [1:0]        src_mode,
    output logic [1:0]        dst_mode,
    output logic              start_cmd,
    output logic              abort_cmd
);

    logic [3:0] mode_q;
    logic       tc_q;
    logic       ctrl_wr;
    logic       ctrl_rd;
    logic       unused_wdata;

    assign unused_wdata = ^cfg_wdata;
    assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL);
    assign ctrl_rd   = cfg_re && (cfg_sel == SEL_CTRL);
    assign start_cmd = ctrl_wr && cfg_wdata[CTL_EN] && !cfg_wdata[CTL_INIT] && !active;
    assign abort_cmd = ctrl_wr && cfg_wdata[CTL_INIT] && active;
    assign src_mode  = mode_q[1:0];
    assign dst_mode  = mode_q[3:2];

    // pending copies: always writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_src <= '0;
            pend_dst <= '0;
            pend_cnt <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_SRC) pend_src <= cfg_wdata[ADDR_W-1:0];
            if (cfg_sel == SEL_DST) pend_dst <= cfg_wdata[ADDR_W-1:0];
            if (cfg_sel == SEL_CNT) pend_cnt <= cfg_wdata[CNT_W-1:0];
        end
    end

    // mode word: frozen while the channel is enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cfg_we && (cfg_sel == SEL_MODE) && !active) begin
            mode_q <= cfg_wdata[3:0];
        end
    end

    // terminal-count flag: set by completion, cleared by read or start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (fin_ev) begin
            tc_q <= 1'b1;
        end else if (ctrl_rd || start_cmd) begin
            tc_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_sel)
            SEL_SRC:  cfg_rdata[ADDR_W-1:0] = pend_src;
            SEL_DST:  cfg_rdata[ADDR_W-1:0] = pend_dst;
            SEL_CNT:  cfg_rdata[CNT_W-1:0]  = pend_cnt;
            SEL_MODE: cfg_rdata[3:0]        = mode_q;
            SEL_CTRL: begin
                cfg_rdata[CTL_EN] = active;
                cfg_rdata[CTL_TC] = tc_q;
            end
            SEL_WSRC: cfg_rdata[ADDR_W-1:0] = work_src;
            SEL_WDST: cfg_rdata[ADDR_W-1:0] = work_dst;
            SEL_WCNT: cfg_rdata[CNT_W-1:0]  = work_cnt;
            default:  cfg_rdata = '0;
        endcase
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        active && cfg_we && (cfg_sel == SEL_MODE) |=> $stable(mode_q)); // R9

    AST_TC_SET_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ev |=> tc_q); // R6

    AST_START_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !fin_ev |=> !tc_q); // R2

endmodule

// File: rtl/dmar_addr.sv
module dmar_addr
    import dmar_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        unique case (mode)
            AM_INC:  addr_nx = addr_q + STEP_V;
            AM_DEC:  addr_nx = addr_q - STEP_V;
            default: addr_nx = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (adv) begin
            addr_q <= addr_nx;
        end
    end

    assign addr = addr_q;

    AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load && mode[1] |=> $stable(addr_q)); // R4

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_q == $past(load_val)); // R2

endmodule

// File: rtl/dmar_fsm.sv
module dmar_fsm
    import dmar_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             abort_cmd,
    input  logic             xfer_req,
    input  logic             bus_gnt,
    input  logic             bus_done,
    input  logic [CNT_W-1:0] pend_cnt,
    output logic             active,
    output logic             bus_req,
    output logic             load_work,
    output logic             adv,
    output logic             fin_ev,
    output logic             irq,
    output logic [CNT_W-1:0] work_cnt
);

    dmar_state_e      state_q, state_nx;
    logic             abort_pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             unit_end;
    logic             stop_now;

    assign unit_end = (state_q == ST_MOVE) && bus_done;
    assign stop_now = abort_pend_q || abort_cmd;

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_cmd) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (abort_cmd)     state_nx = ST_IDLE;
                else if (xfer_req) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (abort_cmd)    state_nx = ST_IDLE;
                else if (bus_gnt) state_nx = ST_MOVE;
            end
            ST_MOVE: begin
                if (bus_done) begin
                    if (stop_now || (cnt_q == '0)) state_nx = ST_IDLE;
                    else                           state_nx = ST_ARMED;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // outputs
    always_comb begin
        active    = 1'b1;
        bus_req   = 1'b0;
        load_work = 1'b0;
        adv       = 1'b0;
        fin_ev    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                active    = 1'b0;
                load_work = start_cmd;
            end
            ST_ARMED: ;
            ST_REQ:   bus_req = 1'b1;
            ST_MOVE: begin
                bus_req = 1'b1;
                adv     = bus_done;
                fin_ev  = bus_done && (cnt_q == '0) && !stop_now;
            end
            default: active = 1'b0;
        endcase
    end

    // count, abort latch, interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            abort_pend_q <= 1'b0;
            irq_q        <= 1'b0;
        end else begin
            irq_q <= fin_ev;
            if (load_work) begin
                cnt_q <= pend_cnt;
            end else if (unit_end && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_nx == ST_IDLE) begin
                abort_pend_q <= 1'b0;
            end else if (abort_cmd && (state_q == ST_MOVE)) begin
                abort_pend_q <= 1'b1;
            end
        end
    end

    assign irq      = irq_q;
    assign work_cnt = cnt_q;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R6

    AST_MOVE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOVE) && !bus_done |=> bus_req); // R3

    AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pend_q && unit_end |=> !irq_q && !active); // R10

    AST_START_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_work |=> cnt_q == $past(pend_cnt)); // R2

    AST_LAST_UNIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        unit_end && (cnt_q == '0) |=> !active); // R5

endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
    import dmar_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP   = 4,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [2:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              xfer_req,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_done,
    output logic [ADDR_W-1:0] bus_src_addr,
    output logic [ADDR_W-1:0] bus_dst_addr,
    output logic              irq_tc
);

    localparam int N_PTR = 2;

    logic              active;
    logic              fin_ev;
    logic              start_cmd;
    logic              abort_cmd;
    logic              load_work;
    logic              adv;
    logic [ADDR_W-1:0] pend_src;
    logic [ADDR_W-1:0] pend_dst;
    logic [CNT_W-1:0]  pend_cnt;
    logic [CNT_W-1:0]  work_cnt;
    logic [1:0]        src_mode;
    logic [1:0]        dst_mode;

    logic [ADDR_W-1:0] ptr_init [N_PTR];
    logic [1:0]        ptr_mode [N_PTR];
    logic [ADDR_W-1:0] ptr_addr [N_PTR];

    assign ptr_init[0] = pend_src;
    assign ptr_init[1] = pend_dst;
    assign ptr_mode[0] = src_mode;
    assign ptr_mode[1] = dst_mode;

    dmar_cfg #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_re    (cfg_re),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .active    (active),
        .fin_ev    (fin_ev),
        .work_src  (ptr_addr[0]),
        .work_dst  (ptr_addr[1]),
        .work_cnt  (work_cnt),
        .pend_src  (pend_src),
        .pend_dst  (pend_dst),
        .pend_cnt  (pend_cnt),
        .src_mode  (src_mode),
        .dst_mode  (dst_mode),
        .start_cmd (start_cmd),
        .abort_cmd (abort_cmd)
    );

    dmar_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .abort_cmd (abort_cmd),
        .xfer_req  (xfer_req),
        .bus_gnt   (bus_gnt),
        .bus_done  (bus_done),
        .pend_cnt  (pend_cnt),
        .active    (active),
        .bus_req   (bus_req),
        .load_work (load_work),
        .adv       (adv),
        .fin_ev    (fin_ev),
        .irq       (irq_tc),
        .work_cnt  (work_cnt)
    );

    for (genvar gi = 0; gi < N_PTR; gi++) begin : g_ptr
        dmar_addr #(
            .ADDR_W (ADDR_W),
            .STEP   (STEP)
        ) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_work),
            .load_val (ptr_init[gi]),
            .adv      (adv),
            .mode     (ptr_mode[gi]),
            .addr     (ptr_addr[gi])
        );
    end

    assign bus_src_addr = ptr_addr[0];
    assign bus_dst_addr = ptr_addr[1];

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bus_req); // R3

    AST_IRQ_ONLY_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_ev |=> !irq_tc); // R6

endmodule

// File: tb/dmar_chan_test.sv
module dmar_chan_test;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int ST = 2;
    localparam int RW = 32;
    localparam int NV = 4;

    // {src mode, dst mode, count, src, dst, final src, final dst}
    localparam logic [75:0] VECS [NV] = '{
        {2'b00, 2'b00, 8'd3, 16'h1000, 16'h2000, 16'h1008, 16'h2008},
        {2'b01, 2'b10, 8'd2, 16'h0002, 16'h3000, 16'hFFFC, 16'h3000},
        {2'b11, 2'b01, 8'd0, 16'h4444, 16'h0100, 16'h4444, 16'h00FE},
        {2'b00, 2'b01, 8'd1, 16'hFFFE, 16'h0010, 16'h0002, 16'h000C}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_re = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          xfer_req = 1'b0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          bus_done = 1'b0;
    logic [AW-1:0] bus_src_addr;
    logic [AW-1:0] bus_dst_addr;
    logic          irq_tc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dmar_chan #(.ADDR_W(AW), .CNT_W(CW), .STEP(ST), .REG_W(RW)) uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_re (cfg_re), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .xfer_req (xfer_req), .bus_req (bus_req), .bus_gnt (bus_gnt),
        .bus_done (bus_done), .bus_src_addr (bus_src_addr),
        .bus_dst_addr (bus_dst_addr), .irq_tc (irq_tc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [31:0] data);
        cfg_sel = sel;
        #1;
        data = cfg_rdata;
    endtask

    task automatic rdclr(output logic [31:0] data);
        cfg_sel = 3'd4; cfg_re = 1'b1;
        #1;
        data = cfg_rdata;
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] m);
        if (m == 2'b00)      return a + AW'(ST);
        else if (m == 2'b01) return a - AW'(ST);
        else                 return a;
    endfunction

    task automatic unit(input logic [AW-1:0] es, input logic [AW-1:0] ed, input logic last);
        logic [31:0] r;
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk("R3 bus_req after request", {31'd0, bus_req}, 32'd1);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk("R4 unit src addr", {16'd0, bus_src_addr}, {16'd0, es});
        chk("R4 unit dst addr", {16'd0, bus_dst_addr}, {16'd0, ed});
        chk("R3 bus_req held in move", {31'd0, bus_req}, 32'd1);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        chk("R6 irq after unit", {31'd0, irq_tc}, {31'd0, last});
        if (!last) begin
            peek(3'd4, r);
            chk("R5 still enabled mid block", r, 32'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd4, r);  chk("R1 control after reset", r, 32'd0);
        peek(3'd0, r);  chk("R1 pending src after reset", r, 32'd0);
        peek(3'd3, r);  chk("R1 mode after reset", r, 32'd0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R1 irq after reset", {31'd0, irq_tc}, 32'd0);

        // R3 request while disabled
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk("R3 request ignored while disabled", {31'd0, bus_req}, 32'd0);

        // vector table: modes, counts, completion, flag clear
        for (int v = 0; v < NV; v++) begin
            logic [1:0]    sm, dm;
            logic [7:0]    cn;
            logic [AW-1:0] sa, da;
            sm = VECS[v][75:74];
            dm = VECS[v][73:72];
            cn = VECS[v][71:64];
            sa = VECS[v][63:48];
            da = VECS[v][47:32];
            wr(3'd0, {16'd0, sa});
            wr(3'd1, {16'd0, da});
            wr(3'd2, {24'd0, cn});
            wr(3'd3, {28'd0, dm, sm});
            wr(3'd4, 32'd1);
            peek(3'd4, r); chk("R2 enabled with flag clear", r, 32'd1);
            peek(3'd5, r); chk("R2 working src loaded", r, {16'd0, sa});
            peek(3'd7, r); chk("R2 working count loaded", r, {24'd0, cn});
            for (int u = 0; u <= int'(cn); u++) begin
                unit(sa, da, u == int'(cn));
                sa = nxt(sa, sm);
                da = nxt(da, dm);
            end
            @(negedge clk);
            chk("R6 irq one cycle", {31'd0, irq_tc}, 32'd0);
            peek(3'd5, r); chk("R4 final src", r, {16'd0, VECS[v][31:16]});
            peek(3'd6, r); chk("R4 final dst", r, {16'd0, VECS[v][15:0]});
            peek(3'd7, r); chk("R5 working count exhausted", r, 32'd0);
            rdclr(r);      chk("R6 flag set, enable clear", r, 32'd4);
            peek(3'd4, r); chk("R7 flag cleared by read", r, 32'd0);
        end

        // R8 buffered writes, R9 mode frozen
        wr(3'd0, 32'h0100);
        wr(3'd1, 32'h0200);
        wr(3'd2, 32'd1);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h0AAA);
        wr(3'd1, 32'h0BBB);
        wr(3'd2, 32'd5);
        wr(3'd3, 32'd5);
        peek(3'd5, r); chk("R8 working src untouched", r, 32'h0100);
        peek(3'd7, r); chk("R8 working count untouched", r, 32'd1);
        peek(3'd0, r); chk("R8 pending src updated", r, 32'h0AAA);
        peek(3'd3, r); chk("R9 mode write ignored", r, 32'd0);
        unit(16'h0100, 16'h0200, 1'b0);
        unit(16'h0102, 16'h0202, 1'b1);
        @(negedge clk);
        rdclr(r);
        wr(3'd4, 32'd1);
        peek(3'd5, r); chk("R8 next start uses new src", r, 32'h0AAA);
        peek(3'd6, r); chk("R8 next start uses new dst", r, 32'h0BBB);
        peek(3'd7, r); chk("R8 next start uses new count", r, 32'd5);

        // R11 start while enabled has no effect
        unit(16'h0AAA, 16'h0BBB, 1'b0);
        wr(3'd0, 32'h0CCC);
        wr(3'd4, 32'd1);
        peek(3'd5, r); chk("R11 restart ignored src", r, 32'h0AAC);
        peek(3'd7, r); chk("R11 restart ignored count", r, 32'd4);

        // R10 abort while waiting
        wr(3'd4, 32'd2);
        peek(3'd4, r); chk("R10 abort while waiting", r, 32'd0);
        chk("R10 no bus after abort", {31'd0, bus_req}, 32'd0);
        chk("R10 no irq after abort", {31'd0, irq_tc}, 32'd0);

        // R11 init beats enable
        wr(3'd4, 32'd3);
        peek(3'd4, r); chk("R11 init has priority", r, 32'd0);

        // R10 abort while moving
        wr(3'd4, 32'd1);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        wr(3'd4, 32'd2);
        chk("R10 bus held until unit done", {31'd0, bus_req}, 32'd1);
        peek(3'd4, r); chk("R10 enable kept until boundary", r, 32'd1);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        chk("R10 no irq on abort", {31'd0, irq_tc}, 32'd0);
        chk("R10 bus released", {31'd0, bus_req}, 32'd0);
        peek(3'd4, r); chk("R10 stopped with flag 0", r, 32'd0);
        peek(3'd5, r); chk("R10 final unit stepped", r, 32'h0CCE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule